// File: doc/BRIEF.md
# Multi-Service Channel Polling Scheduler

This block runs a receiver through a low-power polling loop without help from a host. Fifteen receive channels are grouped as five services of three channels each. A host fills an ordered list of channel indices. After a start pulse the scheduler walks that list. For every real entry it enables the receiver for a listen window and watches a valid-telegram input. When a window closes with nothing heard, it moves to the next entry. After the last entry it sleeps for a programmed time with the receiver off, then begins the list again.

When a telegram is reported during a listen window, the scheduler stops on that channel and raises a host event. The event stays up until the host acknowledges it. The scheduler then goes back to idle and keeps reporting the matching channel. Window and sleep lengths are counted in pulses of a slow tick input. During a window, the configuration word of the channel being listened to is presented to the receiver.

The configuration store has two kinds of slots. The first three services (channels 0 to 8) hold fixed words that cannot be written. The last two services (channels 9 to 14) hold writable words. All writes, including writes to the list and to the timing, are taken only while the scheduler is idle. Any other write is dropped and sets a sticky error flag.

Top module: `poll_sched`

## Requirements
- R1: A `start` pulse while idle begins polling. `busy` is high from the next cycle until the scheduler is back in idle.
- R2: The word of channel i for i in 0..8 is the constant 0xF1C00000 OR i. The words of channels 9..14 reset to zero. `rx_cfg` always shows the word of the channel given by `cur_chan`.
- R3: `rx_en` is high only inside a listen window. A window closes on the clock edge that samples its Nth tick, where N is the window field, and a field of 0 acts as 1.
- R4: List entries are visited in positions 0 to length-1. An entry of 15 is skipped and opens no window. A real entry loads `cur_chan` as the window opens.
- R5: After the last list position, the scheduler sleeps with `rx_en` low until the edge that samples the Sth tick (S is the sleep field, 0 acts as 1). It then restarts at position 0. A length of 0 means it only sleeps.
- R6: `telegram_ok` sampled high during a window raises `host_event` on the next cycle and drops `rx_en`, and this takes priority over a window closing on the same edge. `host_event` stays high until `event_ack` is sampled. `telegram_ok` has no effect outside a window.
- R7: `match_chan` takes the channel that was being listened to when the telegram arrived. An acknowledge returns the scheduler to idle, and `match_chan` keeps its value.
- R8: A write to addresses 0..8, or any write while not idle, changes no stored value and sets `cfg_err`. `cfg_err` clears only on reset.
- R9: After reset the list length is 15 with entry k = k, the window is 4 ticks, the sleep is 8 ticks, and `cur_chan`, `match_chan`, `cfg_err`, `busy`, `rx_en` and `host_event` are zero.
- R10: The write address map is as follows. Addresses 0..14 hold the channel words. Address 15 holds the list length in data bits [3:0]. Addresses 16..30 hold list entries 0..14 in data bits [3:0]. Address 31 holds the timing, with the window in bits [15:0] and the sleep in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Slow time-base pulse, one clock wide |
| start | input | 1 | Begin polling (used only in idle) |
| telegram_ok | input | 1 | Receiver reports a valid telegram |
| event_ack | input | 1 | Host clears the event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |
| rx_en | output | 1 | Receiver enable (listen window) |
| rx_cfg | output | 32 | Configuration word of the current channel |
| cur_chan | output | 4 | Channel of the current or last window |
| host_event | output | 1 | Telegram received, held until acknowledged |
| match_chan | output | 4 | Channel on which the telegram was received |
| busy | output | 1 | Scheduler not idle |
| cfg_err | output | 1 | Sticky flag for rejected writes |

## Verification
The following rules are checked on every cycle: the event holds until it is acknowledged, the event rises only after a telegram in a window, an acknowledge leads to idle with the match kept, polling starts only from a start pulse, the tick counter stays inside its window, the error flag is sticky, and writes while busy are locked out. Other behaviour can only be shown by driving traffic through the bench's reference model. This covers the visiting order with skipped entries, the window and sleep lengths measured in ticks, how a zero field is treated, the priority of a telegram over a closing window, and the fixed words staying untouched after a rejected write.

// File: rtl/poll_pkg.sv
package poll_pkg;
    localparam int NUM_SVC    = 5;
    localparam int CH_PER_SVC = 3;
    localparam int NUM_CH     = NUM_SVC * CH_PER_SVC;
    localparam int FIXED_SVC  = 3;
    localparam int FIXED_CH   = FIXED_SVC * CH_PER_SVC;
    localparam int IDX_W      = 4;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int ADDR_W     = 5;

    localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] A_ORD0 = ADDR_W'(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'(2 * NUM_CH + 1);
    localparam logic [IDX_W-1:0]  SKIP_IDX = '1;

    localparam logic [CNT_W-1:0] RST_WIN   = CNT_W'(4);
    localparam logic [CNT_W-1:0] RST_SLEEP = CNT_W'(8);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_LISTEN,
        ST_SLEEP,
        ST_HOLD
    } poll_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] sleep_ticks;
        logic [CNT_W-1:0] win_ticks;
    } timing_t;

    function automatic logic [WORD_W-1:0] fixed_word(input int unsigned ch);
        return WORD_W'(32'hF1C0_0000) | WORD_W'(ch);
    endfunction
endpackage

// File: rtl/poll_cfg_regs.sv
module poll_cfg_regs
    import poll_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            idle,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic [IDX_W-1:0]                rd_chan,
    output logic [WORD_W-1:0]               rd_word,
    output logic [IDX_W-1:0]                ord_len,
    output logic [NUM_CH-1:0][IDX_W-1:0]    ord_list,
    output timing_t                         timing,
    output logic                            cfg_err
);
    logic                wr_ok;
    logic [WORD_W-1:0]   words [NUM_CH];

    // writes land only in idle and only above the fixed services
    assign wr_ok = wr_en && idle && (wr_addr >= ADDR_W'(FIXED_CH));

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
            if (g < FIXED_CH) begin : g_fixed
                assign words[g] = fixed_word(g);
            end else begin : g_rw
                logic [WORD_W-1:0] word_q;
                always_ff @(posedge clk) begin
                    if (rst)
                        word_q <= '0;
                    else if (wr_ok && wr_addr == ADDR_W'(g))
                        word_q <= wr_data;
                end
                assign words[g] = word_q;
            end
        end
    endgenerate

    assign rd_word = (rd_chan < IDX_W'(NUM_CH)) ? words[rd_chan] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ord_len <= IDX_W'(NUM_CH);
            for (int k = 0; k < NUM_CH; k++)
                ord_list[k] <= IDX_W'(k);
            timing  <= '{sleep_ticks: RST_SLEEP, win_ticks: RST_WIN};
            cfg_err <= 1'b0;
        end else begin
            if (wr_en && !wr_ok)
                cfg_err <= 1'b1;
            if (wr_ok) begin
                if (wr_addr == A_LEN)
                    ord_len <= wr_data[IDX_W-1:0];
                if (wr_addr == A_TIM)
                    timing <= timing_t'(wr_data[2*CNT_W-1:0]);
                for (int k = 0; k < NUM_CH; k++)
                    if (wr_addr == A_ORD0 + ADDR_W'(k))
                        ord_list[k] <= wr_data[IDX_W-1:0];
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err); // R8
    AST_BUSY_WRITE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idle) |=> ($stable(ord_len) && $stable(timing) && $stable(ord_list) && cfg_err)); // R8
endmodule

// File: rtl/poll_tick_timer.sv
module poll_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W:0]   nxt;

    assign nxt  = {1'b0, cnt} + 1'b1;
    // a limit of zero closes on the first tick, same as one
    assign done = tick && !clr && (nxt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clr || done)
            cnt <= '0;
        else if (tick)
            cnt <= nxt[W-1:0];
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !clr |-> (cnt == '0 || cnt < limit)); // R3
endmodule

// File: rtl/poll_seq.sv
module poll_seq
    import poll_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic                            tick,
    input  logic                            telegram_ok,
    input  logic                            event_ack,
    input  logic [IDX_W-1:0]                ord_len,
    input  logic [NUM_CH-1:0][IDX_W-1:0]    ord_list,
    input  timing_t                         timing,
    output logic                            rx_en,
    output logic                            busy,
    output logic                            idle,
    output logic                            event_o,
    output logic [IDX_W-1:0]                cur_chan,
    output logic [IDX_W-1:0]                match_chan
);
    poll_state_e       st;
    logic [IDX_W-1:0]  pos;
    logic [IDX_W-1:0]  entry;
    logic              counting;
    logic [CNT_W-1:0]  limit;
    logic              span_done;

    assign counting = (st == ST_LISTEN) || (st == ST_SLEEP);
    assign limit    = (st == ST_SLEEP) ? timing.sleep_ticks : timing.win_ticks;
    assign entry    = (pos < IDX_W'(NUM_CH)) ? ord_list[pos] : SKIP_IDX;

    poll_tick_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (!counting),
        .tick  (tick),
        .limit (limit),
        .done  (span_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            pos        <= '0;
            cur_chan   <= '0;
            match_chan <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_SELECT;
                        pos <= '0;
                    end
                end
                ST_SELECT: begin
                    if (pos >= ord_len) begin
                        st <= ST_SLEEP;
                    end else if (entry == SKIP_IDX) begin
                        pos <= pos + 1'b1;
                    end else begin
                        cur_chan <= entry;
                        st       <= ST_LISTEN;
                    end
                end
                ST_LISTEN: begin
                    if (telegram_ok) begin
                        match_chan <= cur_chan;
                        st         <= ST_HOLD;
                    end else if (span_done) begin
                        pos <= pos + 1'b1;
                        st  <= ST_SELECT;
                    end
                end
                ST_SLEEP: begin
                    if (span_done) begin
                        pos <= '0;
                        st  <= ST_SELECT;
                    end
                end
                ST_HOLD: begin
                    if (event_ack)
                        st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign rx_en   = (st == ST_LISTEN);
    assign event_o = (st == ST_HOLD);
    assign idle    = (st == ST_IDLE);
    assign busy    = !idle;

    AST_EVENT_HELD: assert property (@(posedge clk) disable iff (rst)
        (event_o && !event_ack) |=> event_o); // R6
    AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(event_o) |-> $past(rx_en && telegram_ok)); // R6
    AST_ACK_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (event_o && event_ack) |=> (!busy && match_chan == $past(match_chan))); // R7
    AST_LISTEN_REAL_CHAN: assert property (@(posedge clk) disable iff (rst)
        rx_en |-> (cur_chan != SKIP_IDX)); // R4
    AST_START_GATES_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R1
endmodule

// File: rtl/poll_sched.sv
module poll_sched
    import poll_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        start,
    input  logic        telegram_ok,
    input  logic        event_ack,
    input  logic        cfg_we,
    input  logic [4:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic        rx_en,
    output logic [31:0] rx_cfg,
    output logic [3:0]  cur_chan,
    output logic        host_event,
    output logic [3:0]  match_chan,
    output logic        busy,
    output logic        cfg_err
);
    logic                           idle;
    logic [IDX_W-1:0]               ord_len;
    logic [NUM_CH-1:0][IDX_W-1:0]   ord_list;
    timing_t                        timing;

    poll_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .idle     (idle),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .rd_chan  (cur_chan),
        .rd_word  (rx_cfg),
        .ord_len  (ord_len),
        .ord_list (ord_list),
        .timing   (timing),
        .cfg_err  (cfg_err)
    );

    poll_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .tick        (tick),
        .telegram_ok (telegram_ok),
        .event_ack   (event_ack),
        .ord_len     (ord_len),
        .ord_list    (ord_list),
        .timing      (timing),
        .rx_en       (rx_en),
        .busy        (busy),
        .idle        (idle),
        .event_o     (host_event),
        .cur_chan    (cur_chan),
        .match_chan  (match_chan)
    );

    AST_RXCFG_STEADY: assert property (@(posedge clk) disable iff (rst)
        (rx_en && $past(rx_en)) |-> $stable(rx_cfg)); // R2
endmodule

// File: tb/poll_sched_tb_top.sv
module poll_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic        telegram_ok = 1'b0;
    logic        event_ack = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_en;
    logic [31:0] rx_cfg;
    logic [3:0]  cur_chan;
    logic        host_event;
    logic [3:0]  match_chan;
    logic        busy;
    logic        cfg_err;

    always #2 clk = ~clk;

    poll_sched dut_i (
        .clk(clk), .rst(rst), .tick(tick), .start(start),
        .telegram_ok(telegram_ok), .event_ack(event_ack),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_en(rx_en), .rx_cfg(rx_cfg), .cur_chan(cur_chan),
        .host_event(host_event), .match_chan(match_chan),
        .busy(busy), .cfg_err(cfg_err)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  cmp_on = 1'b0;
    bit  fin = 1'b0;
    int  cyc = 0;
    int  tick_per = 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // behavioural reference: modes 0 idle, 1 choose, 2 listen, 3 sleep, 4 held
    int          m_mode, m_pos, m_cnt, m_cur, m_match, m_len, m_win, m_slp;
    bit          m_err;
    logic [31:0] m_word [15];
    int          m_ord [15];

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_pos = 0; m_cnt = 0; m_cur = 0; m_match = 0;
            m_len = 15; m_win = 4; m_slp = 8; m_err = 1'b0;
            for (int i = 0; i < 15; i++) begin
                m_word[i] = (i < 9) ? (32'hF1C0_0000 | i) : 32'h0;
                m_ord[i]  = i;
            end
        end else begin
            if (cfg_we) begin
                if (m_mode != 0 || cfg_addr < 9) m_err = 1'b1;
                else if (cfg_addr < 15) m_word[cfg_addr] = cfg_wdata;
                else if (cfg_addr == 15) m_len = cfg_wdata[3:0];
                else if (cfg_addr == 31) begin
                    m_win = cfg_wdata[15:0];
                    m_slp = cfg_wdata[31:16];
                end else m_ord[cfg_addr - 16] = cfg_wdata[3:0];
            end
            case (m_mode)
                0: if (start) begin m_mode = 1; m_pos = 0; end
                1: begin
                    if (m_pos >= m_len) begin m_mode = 3; m_cnt = 0; end
                    else if (m_ord[m_pos] == 15) m_pos++;
                    else begin m_cur = m_ord[m_pos]; m_mode = 2; m_cnt = 0; end
                end
                2: begin
                    if (telegram_ok) begin m_mode = 4; m_match = m_cur; end
                    else if (tick) begin
                        m_cnt++;
                        if (m_cnt >= at_least_one(m_win)) begin m_pos++; m_mode = 1; end
                    end
                end
                3: if (tick) begin
                    m_cnt++;
                    if (m_cnt >= at_least_one(m_slp)) begin m_pos = 0; m_mode = 1; end
                end
                4: if (event_ack) m_mode = 0;
                default: m_mode = 0;
            endcase
        end
    end

    // compare on every clock, away from the active edge; also drive tick
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk("R1", "busy",       32'(busy),       32'(m_mode != 0));
            chk("R3", "rx_en",      32'(rx_en),      32'(m_mode == 2));
            chk("R4", "cur_chan",   32'(cur_chan),   32'(m_cur));
            chk("R2", "rx_cfg",     rx_cfg,          m_word[m_cur]);
            chk("R6", "host_event", 32'(host_event), 32'(m_mode == 4));
            chk("R7", "match_chan", 32'(match_chan), 32'(m_match));
            chk("R8", "cfg_err",    32'(cfg_err),    32'(m_err));
        end
        tick = (tick_per > 0) && (cyc % tick_per == 0);
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); event_ack = 1'b1;
        @(negedge clk); event_ack = 1'b0;
    endtask

    task automatic wait_listen(input int ch, output bit found);
        found = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (rx_en && cur_chan == ch) begin found = 1'b1; break; end
        end
    endtask

    task automatic window_ticks(output int n);
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            #1;
            if (!rx_en) break;
            if (tick) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        bit found;
        int n;
        int seen [$];
        int hi;
        bit prev;

        repeat (2) @(negedge clk);
        cmp_on = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        // R9: reset state
        chk("R9", "busy",     32'(busy), 0);
        chk("R9", "rx_en",    32'(rx_en), 0);
        chk("R9", "event",    32'(host_event), 0);
        chk("R9", "cfg_err",  32'(cfg_err), 0);
        chk("R9", "match",    32'(match_chan), 0);
        chk("R2", "rx_cfg ch0", rx_cfg, 32'hF1C0_0000);

        // R9 / R3: default list starts at channel 0 with a 4-tick window
        tick_per = 1;
        pulse_start();
        wait_listen(0, found);
        chk("R9", "first window on ch0", 32'(found), 1);
        window_ticks(n);
        chk("R3", "default window ticks", n, 4);

        // R6 priority over a closing window, R7 match and return to idle
        wait_listen(5, found);
        chk("R4", "reached ch5", 32'(found), 1);
        chk("R2", "rx_cfg ch5", rx_cfg, 32'hF1C0_0005);
        repeat (3) @(negedge clk);
        telegram_ok = 1'b1;
        @(negedge clk); telegram_ok = 1'b0;
        #1;
        chk("R6", "event after telegram", 32'(host_event), 1);
        chk("R6", "rx_en off in hold", 32'(rx_en), 0);
        chk("R7", "match ch5", 32'(match_chan), 5);
        repeat (5) @(negedge clk);
        telegram_ok = 1'b1;
        @(negedge clk); telegram_ok = 1'b0;
        #1;
        chk("R6", "event held", 32'(host_event), 1);
        chk("R7", "match unchanged", 32'(match_chan), 5);
        pulse_ack();
        #1;
        chk("R7", "idle after ack", 32'(busy), 0);
        chk("R7", "match kept", 32'(match_chan), 5);

        // R8: write to a fixed slot in idle
        wr(5'd4, 32'hDEAD_BEEF);
        #1;
        chk("R8", "err on fixed write", 32'(cfg_err), 1);
        pulse_start();
        wait_listen(4, found);
        chk("R8", "fixed word intact", rx_cfg, 32'hF1C0_0004);
        pulse_ack();

        // R8: write while busy is dropped
        do_reset();
        #1;
        chk("R8", "err cleared by reset", 32'(cfg_err), 0);
        pulse_start();
        wr(5'd20, 32'h0000_000F);
        #1;
        chk("R8", "err on busy write", 32'(cfg_err), 1);
        wait_listen(4, found);
        chk("R8", "entry 4 unchanged", 32'(found), 1);

        // R10 / R4 / R5: custom list with skips
        do_reset();
        tick_per = 3;
        wr(5'd15, 32'd5);
        wr(5'd16, 32'd10);
        wr(5'd17, 32'd15);
        wr(5'd18, 32'd3);
        wr(5'd19, 32'd15);
        wr(5'd20, 32'd12);
        wr(5'd31, {16'd3, 16'd2});
        wr(5'd10, 32'h1234_5678);
        wr(5'd12, 32'hCAFE_0012);
        #1;
        chk("R10", "legal writes no err", 32'(cfg_err), 0);
        pulse_start();
        prev = 1'b0;
        for (int i = 0; i < 400 && seen.size() < 6; i++) begin
            @(negedge clk); #1;
            if (rx_en && !prev) seen.push_back(int'(cur_chan));
            if (rx_en && cur_chan == 10) chk("R2", "rx_cfg ch10", rx_cfg, 32'h1234_5678);
            prev = rx_en;
        end
        chk("R4", "visits", seen.size(), 6);
        for (int i = 0; i < seen.size(); i++) begin
            int exp_ch;
            exp_ch = (i % 3 == 0) ? 10 : ((i % 3 == 1) ? 3 : 12);
            chk("R4", "visit order", seen[i], exp_ch);
        end
        wait_listen(12, found);
        chk("R2", "rx_cfg ch12", rx_cfg, 32'hCAFE_0012);
        @(negedge clk); telegram_ok = 1'b1;
        @(negedge clk); telegram_ok = 1'b0;
        #1;
        chk("R7", "match ch12", 32'(match_chan), 12);
        pulse_ack();

        // R5: empty list only sleeps
        do_reset();
        tick_per = 2;
        wr(5'd15, 32'd0);
        wr(5'd31, {16'd2, 16'd1});
        pulse_start();
        hi = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #1;
            if (rx_en) hi++;
        end
        chk("R5", "no window with length 0", hi, 0);
        chk("R5", "still busy", 32'(busy), 1);

        // R3: zero window field acts as one tick
        do_reset();
        wr(5'd31, {16'd1, 16'd0});
        pulse_start();
        wait_listen(0, found);
        window_ticks(n);
        chk("R3", "zero window ticks", n, 1);
        wait_listen(1, found);
        chk("R4", "next channel reached", 32'(found), 1);

        repeat (4) @(negedge clk);
        report();
    end
endmodule